// File: doc/BRIEF.md
# Motor Lock Protection Timer

This block guards a brushless motor drive against a stalled rotor. While the drive is commanded to run and the speed loop reports that the rotor is out of speed lock, a digital counter advances on every pulse of a slow timebase. Once the count reaches a programmed limit, a trip flag is latched. The low-side drivers are gated off by this flag. A digital counter takes the place of the charging capacitor that would set this delay in an analog design.

The trip flag is cleared only when the run command is withdrawn or when power-on reset is applied. During stop, the counter drains by a fixed step on every timebase pulse. It is empty only after the full reset stop time. If a stop is shorter than that, the residual count carries over, and the next timeout comes early. When lock detect shows in-lock during run, the counter returns to zero. Tying the enable strap low removes protection completely.

The controller has six states:
- `ST_OFF`: protection disabled.
- `ST_STOP`: stopped with an empty counter.
- `ST_DRAIN`: stopped while the counter drains.
- `ST_LOCKED`: running in lock.
- `ST_TIMING`: running out of lock while counting.
- `ST_TRIPPED`: trip latched.

The transitions are:
- Strap low leads from any state to `ST_OFF`.
- Run low leads to `ST_DRAIN`, or to `ST_STOP` when the drain empties the counter.
- Run with lock detect in-lock leads from any state except `ST_TRIPPED` to `ST_LOCKED`.
- Run out of lock leads from any state except `ST_TRIPPED` to `ST_TIMING`.
- `ST_TIMING` leads to `ST_TRIPPED` on the pulse that reaches the limit, or at once if the carried count is already full.
- `ST_TRIPPED` holds until run or strap falls.

The default values model a 1 ms timebase, a 3.3 s timeout and a 150 ms full drain.

Top module: `lock_prot_timer`

## Requirements
- R1: After power-on reset (`rst_n` low), `trip` is 0 and the count is zero, so the next timeout needs the full TRIP_TICKS pulses.
- R2: With `prot_en`=1, `run_cmd`=1 and `unlocked`=1, starting from an empty count, `trip` rises at the clock edge that samples the TRIP_TICKS-th `tick`. It is still 0 after the edge that samples the previous pulse.
- R3: In a cycle where `run_cmd`=1, `prot_en`=1 and `unlocked`=0, with no trip latched, the count is cleared to zero. This also holds when the cycle carries a `tick` that would have completed the timeout.
- R4: Once `trip` is 1, it stays 1 while `run_cmd` and `prot_en` stay 1, whatever `unlocked` and `tick` do.
- R5: The first clock edge that samples `run_cmd`=0 drives `trip` to 0. Stop takes precedence over a final counting pulse in the same cycle.
- R6: During stop, each `tick` lowers the count by DRAIN_STEP, saturating at zero. After ceil(TRIP_TICKS/DRAIN_STEP) stop pulses, a restart needs the full TRIP_TICKS pulses.
- R7: A stop that is too short leaves residual count max(0, C − k·DRAIN_STEP), where C is the count at stop and k is the number of stop pulses. The next timeout then needs only TRIP_TICKS minus that residual.
- R8: While `prot_en`=0, `trip` is driven to 0 on the next edge, the count is cleared and no trip occurs. After the strap returns to 1, a timeout needs the full TRIP_TICKS pulses.
- R9: The count changes only in cycles with `tick`=1, except for the clears in R3 and R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick | input | 1 | Timebase pulse, one clock wide, qualifies counting and draining |
| run_cmd | input | 1 | 1 = start (motor commanded to run), 0 = stop |
| unlocked | input | 1 | Lock detect level: 1 = speed out of lock, 0 = in lock |
| prot_en | input | 1 | Protection enable strap, 0 disables the function |
| trip | output | 1 | Registered latched trip flag; 1 turns the low-side drivers off |

## Verification
Two functions can fall in the same cycle: the final counting pulse that would complete the timeout, and either a lock-detect fall or a stop command. The bench brings the count to one below the limit. It then drives `tick` together with `unlocked`=0 in one cycle, and in a second run it drives `tick` together with `run_cmd`=0. In both cases `trip` must stay 0. The follow-up run shows whether the count was cleared in the first case. In the second case it shows the residual left after a single drain step.

// File: rtl/lockprot_pkg.sv
package lockprot_pkg;

    typedef enum logic [2:0] {
        ST_OFF     = 3'd0,
        ST_STOP    = 3'd1,
        ST_DRAIN   = 3'd2,
        ST_LOCKED  = 3'd3,
        ST_TIMING  = 3'd4,
        ST_TRIPPED = 3'd5
    } prot_state_t;

    typedef enum logic [1:0] {
        CNT_HOLD  = 2'd0,
        CNT_CLEAR = 2'd1,
        CNT_UP    = 2'd2,
        CNT_DRAIN = 2'd3
    } cnt_cmd_t;

endpackage

// File: rtl/lockprot_counter.sv
module lockprot_counter
    import lockprot_pkg::*;
#(
    parameter int TRIP_TICKS = 3300,
    parameter int DRAIN_STEP = 22
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                tick,
    input  cnt_cmd_t                            cmd,
    output logic [$clog2(TRIP_TICKS+1)-1:0]     cnt,
    output logic                                cnt_zero,
    output logic                                cnt_full,
    output logic                                up_last,
    output logic                                drain_last
);

    localparam int CW       = $clog2(TRIP_TICKS + 1);
    localparam int SAT_STEP = (DRAIN_STEP > TRIP_TICKS) ? TRIP_TICKS : DRAIN_STEP;
    localparam logic [CW-1:0] LIMIT_C = CW'(TRIP_TICKS);
    localparam logic [CW-1:0] LAST_C  = CW'(TRIP_TICKS - 1);
    localparam logic [CW-1:0] STEP_C  = CW'(SAT_STEP);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    assign cnt        = cnt_q;
    assign cnt_zero   = (cnt_q == '0);
    assign cnt_full   = (cnt_q >= LIMIT_C);
    assign up_last    = (cnt_q == LAST_C);
    assign drain_last = (cnt_q <= STEP_C);

    always_comb begin
        cnt_d = cnt_q;
        unique case (cmd)
            CNT_CLEAR: cnt_d = '0;
            CNT_UP: begin
                if (tick && !cnt_full) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            CNT_DRAIN: begin
                if (tick) begin
                    cnt_d = drain_last ? '0 : (cnt_q - STEP_C);
                end
            end
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/lockprot_fsm.sv
module lockprot_fsm
    import lockprot_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        run_cmd,
    input  logic        unlocked,
    input  logic        prot_en,
    input  logic        cnt_zero,
    input  logic        cnt_full,
    input  logic        up_last,
    input  logic        drain_last,
    output cnt_cmd_t    cmd,
    output prot_state_t state,
    output logic        trip
);

    prot_state_t state_q;
    prot_state_t state_d;
    logic        trip_q;

    assign state = state_q;
    assign trip  = trip_q;

    // Next-state and counter command decode
    always_comb begin
        state_d = state_q;
        cmd     = CNT_HOLD;
        if (!prot_en) begin
            state_d = ST_OFF;
            cmd     = CNT_CLEAR;
        end else if (!run_cmd) begin
            cmd     = CNT_DRAIN;
            state_d = (cnt_zero || (tick && drain_last)) ? ST_STOP : ST_DRAIN;
        end else begin
            unique case (state_q)
                ST_TRIPPED: begin
                    state_d = ST_TRIPPED;
                    cmd     = CNT_HOLD;
                end
                ST_OFF, ST_STOP, ST_DRAIN, ST_LOCKED, ST_TIMING: begin
                    if (!unlocked) begin
                        state_d = ST_LOCKED;
                        cmd     = CNT_CLEAR;
                    end else begin
                        cmd     = CNT_UP;
                        state_d = (cnt_full || (tick && up_last)) ? ST_TRIPPED
                                                                 : ST_TIMING;
                    end
                end
                default: begin
                    state_d = ST_OFF;
                    cmd     = CNT_CLEAR;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // Registered output
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trip_q <= 1'b0;
        end else begin
            trip_q <= (state_d == ST_TRIPPED);
        end
    end

endmodule

// File: rtl/lock_prot_timer.sv
module lock_prot_timer
    import lockprot_pkg::*;
#(
    parameter int TRIP_TICKS = 3300,
    parameter int DRAIN_STEP = 22
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run_cmd,
    input  logic unlocked,
    input  logic prot_en,
    output logic trip
);

    localparam int CW = $clog2(TRIP_TICKS + 1);

    cnt_cmd_t    cnt_cmd;
    prot_state_t fsm_state;
    logic [CW-1:0] cnt_q;
    logic        cnt_zero;
    logic        cnt_full;
    logic        up_last;
    logic        drain_last;

    lockprot_counter #(
        .TRIP_TICKS (TRIP_TICKS),
        .DRAIN_STEP (DRAIN_STEP)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cmd        (cnt_cmd),
        .cnt        (cnt_q),
        .cnt_zero   (cnt_zero),
        .cnt_full   (cnt_full),
        .up_last    (up_last),
        .drain_last (drain_last)
    );

    lockprot_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .run_cmd    (run_cmd),
        .unlocked   (unlocked),
        .prot_en    (prot_en),
        .cnt_zero   (cnt_zero),
        .cnt_full   (cnt_full),
        .up_last    (up_last),
        .drain_last (drain_last),
        .cmd        (cnt_cmd),
        .state      (fsm_state),
        .trip       (trip)
    );

endmodule

// File: rtl/lockprot_chk.sv
module lockprot_chk #(
    parameter int TRIP_TICKS = 3300
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              tick,
    input logic                              run_cmd,
    input logic                              unlocked,
    input logic                              prot_en,
    input logic                              trip,
    input logic [$clog2(TRIP_TICKS+1)-1:0]   cnt
);

    localparam int CW = $clog2(TRIP_TICKS + 1);
    localparam logic [CW-1:0] LIMIT_C = CW'(TRIP_TICKS);

    AST_RISE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trip) |-> $past(run_cmd && unlocked && prot_en)); // R2

    AST_LOCK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && run_cmd && !unlocked && !trip) |=> (cnt == '0)); // R3

    AST_TRIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (trip && run_cmd && prot_en) |=> trip); // R4

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_cmd) |=> !trip); // R5

    AST_DRAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && !run_cmd && tick && (cnt != '0)) |=> (cnt < $past(cnt))); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT_C); // R7

    AST_STRAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_en) |=> (!trip && (cnt == '0))); // R8

    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && run_cmd && unlocked && !tick) |=> $stable(cnt)); // R9

endmodule

bind lock_prot_timer lockprot_chk #(
    .TRIP_TICKS (TRIP_TICKS)
) u_lockprot_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .run_cmd  (run_cmd),
    .unlocked (unlocked),
    .prot_en  (prot_en),
    .trip     (trip),
    .cnt      (cnt_q)
);

// File: tb/test_lock_prot_timer.sv
`timescale 1ns/1ps
module test_lock_prot_timer;

    localparam int TRIP = 20;
    localparam int STEP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic run_cmd = 1'b0;
    logic unlocked = 1'b0;
    logic prot_en = 1'b1;
    logic trip;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lock_prot_timer #(
        .TRIP_TICKS (TRIP),
        .DRAIN_STEP (STEP)
    ) i_lock_prot_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run_cmd  (run_cmd),
        .unlocked (unlocked),
        .prot_en  (prot_en),
        .trip     (trip)
    );

    typedef struct packed {
        logic       run;
        logic       unl;
        logic       en;
        logic [7:0] n;
        logic       exp;
        logic [3:0] req;
    } vec_t;

    // Stimulus walk; count model noted per row (TRIP=20, STEP=4)
    localparam vec_t VEC [18] = '{
        '{1'b0, 1'b1, 1'b1, 8'd5,  1'b0, 4'd5},  // R5 stop, count 0
        '{1'b1, 1'b1, 1'b1, 8'd19, 1'b0, 4'd2},  // R2 count 19
        '{1'b1, 1'b1, 1'b1, 8'd1,  1'b1, 4'd2},  // R2 count 20 trips
        '{1'b1, 1'b0, 1'b1, 8'd3,  1'b1, 4'd4},  // R4 latched despite lock
        '{1'b0, 1'b1, 1'b1, 8'd0,  1'b0, 4'd5},  // R5 stop clears, count 20
        '{1'b0, 1'b1, 1'b1, 8'd2,  1'b0, 4'd7},  // R7 short stop, count 12
        '{1'b1, 1'b1, 1'b1, 8'd7,  1'b0, 4'd7},  // R7 count 19
        '{1'b1, 1'b1, 1'b1, 8'd1,  1'b1, 4'd7},  // R7 early timeout
        '{1'b0, 1'b1, 1'b1, 8'd5,  1'b0, 4'd6},  // R6 full drain
        '{1'b1, 1'b1, 1'b1, 8'd19, 1'b0, 4'd6},  // R6 full time needed
        '{1'b1, 1'b0, 1'b1, 8'd0,  1'b0, 4'd3},  // R3 relock clears
        '{1'b1, 1'b1, 1'b1, 8'd19, 1'b0, 4'd3},  // R3 count 19 from zero
        '{1'b1, 1'b1, 1'b1, 8'd0,  1'b0, 4'd9},  // R9 no tick, held at 19
        '{1'b1, 1'b1, 1'b1, 8'd1,  1'b1, 4'd9},  // R9 one tick trips
        '{1'b1, 1'b1, 1'b0, 8'd0,  1'b0, 4'd8},  // R8 strap off drops trip
        '{1'b1, 1'b1, 1'b0, 8'd40, 1'b0, 4'd8},  // R8 never trips
        '{1'b1, 1'b1, 1'b1, 8'd19, 1'b0, 4'd8},  // R8 count was cleared
        '{1'b1, 1'b1, 1'b1, 8'd1,  1'b1, 4'd8}   // R8 full timeout
    };

    task automatic check(input logic got, input logic exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: trip=%0b expected=%0b", what, got, exp);
        end
    endtask

    task automatic apply(input logic r, input logic u, input logic e, input int n);
        @(negedge clk);
        run_cmd = r; unlocked = u; prot_en = e; tick = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: trip=%0b expected=finish", trip);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check(trip, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(trip, 1'b0, "R1 after reset");

        // Table walk
        for (int v = 0; v < 18; v++) begin
            apply(VEC[v].run, VEC[v].unl, VEC[v].en, int'(VEC[v].n));
            check(trip, VEC[v].exp, $sformatf("R%0d vector %0d", VEC[v].req, v));
        end

        // R2 exact edge of the final tick
        apply(1'b0, 1'b1, 1'b1, 5);
        @(negedge clk);
        run_cmd = 1'b1; unlocked = 1'b1; tick = 1'b1;
        repeat (19) @(negedge clk);
        check(trip, 1'b0, "R2 after 19th tick");
        @(negedge clk);
        check(trip, 1'b1, "R2 after 20th tick");
        tick = 1'b0;

        // R3 lock drop in the same cycle as the final tick
        apply(1'b0, 1'b1, 1'b1, 5);
        apply(1'b1, 1'b1, 1'b1, 19);
        @(negedge clk);
        unlocked = 1'b0; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(trip, 1'b0, "R3 lock wins over final tick");
        apply(1'b1, 1'b1, 1'b1, 19);
        check(trip, 1'b0, "R3 count cleared on lock");
        apply(1'b1, 1'b1, 1'b1, 1);
        check(trip, 1'b1, "R3 full timeout after clear");

        // R5 stop in the same cycle as the final tick, then R7 residual
        apply(1'b0, 1'b1, 1'b1, 5);
        apply(1'b1, 1'b1, 1'b1, 19);
        @(negedge clk);
        run_cmd = 1'b0; tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check(trip, 1'b0, "R5 stop wins over final tick");
        apply(1'b1, 1'b1, 1'b1, 4);
        check(trip, 1'b0, "R7 residual 15 plus 4");
        apply(1'b1, 1'b1, 1'b1, 1);
        check(trip, 1'b1, "R7 residual 15 plus 5");

        // R1 reset while tripped
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(trip, 1'b0, "R1 reset drops trip");
        rst_n = 1'b1;
        apply(1'b1, 1'b1, 1'b1, 19);
        check(trip, 1'b0, "R1 count zero after reset");
        apply(1'b1, 1'b1, 1'b1, 1);
        check(trip, 1'b1, "R1 full timeout after reset");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule